// File: doc/BRIEF.md
# Dual-Edge Input Capture Timer

This block keeps time for a small controller. A 16-bit free-running counter advances on every clock and can be preset through two byte writes. A 12-bit down-counting interval timer reloads itself from a programmable period register and raises an interrupt flag each time it runs out. Two input capture channels watch asynchronous pins. Each channel records a snapshot of the counter in one register on a rising edge and in another register on a falling edge.

In 8-bit mode each channel captures the low byte of the counter. In paired mode, edges on channel 0 alone fill both channels: channel 0 registers receive the low byte and channel 1 registers receive the high byte of the same sample. A hold option keeps the first captured value in a register until software reads it. Every capture edge and every timer expiry sets a sticky flag. Software clears a flag by writing 1 to it. A per-flag mask gates the flags onto the interrupt vector. Software reaches all state through a byte-wide register bus whose read data is registered.

Top module: `edge_capture_timer`

## Requirements
- R1: After reset, `irq` is 0, every flag, control, mask and capture register reads 0, and an access to an unmapped address (4..7 excepted only where mapped: 7 and 12..15 are unmapped) reads 0.
- R2: Writing address 0 stores a low byte and writing address 1 loads the counter with {wdata, stored byte}. A read of address 0 (low) or 1 (high) in the next cycle returns the loaded value, and the counter then rises by one per clock, wrapping from 0xFFFF to 0.
- R3: A level change on `cap_in[c]` that is driven just after the counter takes value V stores V+2 (low byte) in the channel's rise register (rising edge) or fall register (falling edge). Register addresses are 8 for ch0 rise, 9 for ch0 fall, 10 for ch1 rise and 11 for ch1 fall.
- R4: In 8-bit mode, a capture on one channel leaves the other channel's registers unchanged.
- R5: With control bit 0 set (paired mode), a channel 0 edge writes the low byte to the channel 0 register and the high byte to the channel 1 register of the same edge type. `cap_in[1]` edges then change no register and set no flag.
- R6: With control bit 1 set (hold mode), a capture register that has captured keeps its value on later edges until it is read. The read returns the first value and re-arms the register.
- R7: The interval timer period is the 12-bit value at addresses 2 (low byte) and 3 (high nibble) plus one clock. A write to address 3 restarts the count from the new period. Each expiry sets flag bit 4.
- R8: The flag register at address 6 has these bits: 0 ch0 rise, 1 ch0 fall, 2 ch1 rise, 3 ch1 fall, 4 timer. A flag set by its event stays set until a write to address 6 with a 1 in that bit clears it. Writing 0 to a bit leaves it unchanged.
- R9: `irq` equals the flags ANDed with the mask at address 5, so a flag with its mask bit clear drives no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_in | input | 2 | Asynchronous capture inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | 5 | Masked interrupt flags |

## Verification
The assertions assume that a read and a write never share a cycle, and that only addresses 1, 3 and 6 alter the counter, the interval timer and the flags respectively. The bench issues exactly one bus operation per clock, each from a task that starts and ends at a falling edge, so every access is isolated. Each capture input changes only after enough settled clocks for the synchroniser to pass every level change through. The bench always alternates the input levels, so each change is a single clean edge.

// File: rtl/ect_pkg.sv
package ect_pkg;
   localparam int unsigned AW    = 4;
   localparam int unsigned N_IRQ = 5;

   localparam logic [AW-1:0] A_FRT_LO = 4'd0;
   localparam logic [AW-1:0] A_FRT_HI = 4'd1;
   localparam logic [AW-1:0] A_PT_LO  = 4'd2;
   localparam logic [AW-1:0] A_PT_HI  = 4'd3;
   localparam logic [AW-1:0] A_CTRL   = 4'd4;
   localparam logic [AW-1:0] A_MASK   = 4'd5;
   localparam logic [AW-1:0] A_FLAG   = 4'd6;
   localparam logic [AW-1:0] A_C0R    = 4'd8;
   localparam logic [AW-1:0] A_C0F    = 4'd9;

   // flag bit of the interval timer; capture flags occupy 0..3
   localparam int unsigned F_PT = 4;
endpackage

// File: rtl/ect_edge_sync.sv
module ect_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   // stages 0..STAGES-1 synchronise, stage STAGES remembers previous level
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], din};
   end

   assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
   assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/ect_free_counter.sv
module ect_free_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)    count <= '0;
      else if (load) count <= load_val;
      else           count <= count + 1'b1;
   end
endmodule

// File: rtl/ect_prog_timer.sv
module ect_prog_timer #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic [W-1:0] restart_val,
   input  logic [W-1:0] reload_val,
   output logic [W-1:0] count,
   output logic         expire
);
   assign expire = (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)       count <= '1;
      else if (restart) count <= restart_val;
      else if (expire)  count <= reload_val;
      else              count <= count - 1'b1;
   end
endmodule

// File: rtl/edge_capture_timer.sv
module edge_capture_timer
   import ect_pkg::*;
#(
   parameter int unsigned CAP_W       = 8,
   parameter int unsigned PT_W        = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cap_in,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [AW-1:0]    addr,
   input  logic [CAP_W-1:0] wdata,
   output logic [CAP_W-1:0] rdata,
   output logic [N_IRQ-1:0] irq
);
   localparam int unsigned CNT_W   = 2 * CAP_W;
   localparam int unsigned PT_HI_W = PT_W - CAP_W;
   localparam int unsigned NCH     = 2;
   localparam int unsigned NCAP    = 2 * NCH;

   if (PT_W <= CAP_W || PT_W > CNT_W) begin : g_bad_pt_w
      $error("PT_W must lie in (CAP_W, 2*CAP_W]");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [CAP_W-1:0]             frt_stage;
   logic [CNT_W-1:0]             frt;
   logic [PT_W-1:0]              pt_reload;
   logic [PT_W-1:0]              pt_count;
   logic                         pt_expire;
   logic                         pair_mode, hold_mode;
   logic [N_IRQ-1:0]             irq_mask, irq_flag, flag_set;
   logic [NCAP-1:0][CAP_W-1:0]   cap_q, sample;
   logic [NCAP-1:0]              hold_flag, ev_raw, ev_eff, gate, cap_we, rd_hit;
   logic [CAP_W-1:0]             rd_val;

   logic frt_load, pt_restart;
   assign frt_load   = wr_en && (addr == A_FRT_HI);
   assign pt_restart = wr_en && (addr == A_PT_HI);

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      ect_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (cap_in[ch]),
         .rise (ev_raw[2*ch]),
         .fall (ev_raw[2*ch+1])
      );
   end

   ect_free_counter #(.W(CNT_W)) u_frt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (frt_load),
      .load_val({wdata, frt_stage}),
      .count   (frt)
   );

   ect_prog_timer #(.W(PT_W)) u_pt (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (pt_restart),
      .restart_val({wdata[PT_HI_W-1:0], pt_reload[CAP_W-1:0]}),
      .reload_val (pt_reload),
      .count      (pt_count),
      .expire     (pt_expire)
   );

   // event routing: paired mode steers channel 0 edges onto both channels
   always_comb begin
      for (int k = 0; k < NCAP; k++) begin
         if (pair_mode) begin
            ev_eff[k]   = ev_raw[k % 2];
            gate[k]     = hold_flag[k % 2];
            sample[k]   = (k < 2) ? frt[CAP_W-1:0] : frt[CNT_W-1:CAP_W];
            flag_set[k] = (k < 2) ? ev_raw[k] : 1'b0;
         end else begin
            ev_eff[k]   = ev_raw[k];
            gate[k]     = hold_flag[k];
            sample[k]   = frt[CAP_W-1:0];
            flag_set[k] = ev_raw[k];
         end
         cap_we[k] = ev_eff[k] && !(hold_mode && gate[k]);
         rd_hit[k] = rd_en && (addr[AW-1:2] == A_C0R[AW-1:2]) && (addr[1:0] == k[1:0]);
      end
      flag_set[F_PT] = pt_expire;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_q     <= '0;
         hold_flag <= '0;
      end else begin
         for (int k = 0; k < NCAP; k++) begin
            if (cap_we[k]) cap_q[k] <= sample[k];
            if (cap_we[k] && hold_mode) hold_flag[k] <= 1'b1;
            else if (rd_hit[k])         hold_flag[k] <= 1'b0;
         end
      end
   end

   // software-visible control, mask and flags
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frt_stage <= '0;
         pt_reload <= '1;
         pair_mode <= 1'b0;
         hold_mode <= 1'b0;
         irq_mask  <= '0;
         irq_flag  <= '0;
      end else begin
         if (wr_en) begin
            case (addr)
               A_FRT_LO: frt_stage <= wdata;
               A_PT_LO:  pt_reload[CAP_W-1:0] <= wdata;
               A_PT_HI:  pt_reload[PT_W-1:CAP_W] <= wdata[PT_HI_W-1:0];
               A_CTRL: begin
                  pair_mode <= wdata[0];
                  hold_mode <= wdata[1];
               end
               A_MASK:   irq_mask <= wdata[N_IRQ-1:0];
               default: ;
            endcase
         end
         if (wr_en && addr == A_FLAG) irq_flag <= (irq_flag & ~wdata[N_IRQ-1:0]) | flag_set;
         else                         irq_flag <= irq_flag | flag_set;
      end
   end

   always_comb begin
      rd_val = '0;
      case (addr)
         A_FRT_LO: rd_val = frt[CAP_W-1:0];
         A_FRT_HI: rd_val = frt[CNT_W-1:CAP_W];
         A_PT_LO:  rd_val = pt_reload[CAP_W-1:0];
         A_PT_HI:  rd_val = CAP_W'(pt_reload[PT_W-1:CAP_W]);
         A_CTRL:   rd_val = CAP_W'({hold_mode, pair_mode});
         A_MASK:   rd_val = CAP_W'(irq_mask);
         A_FLAG:   rd_val = CAP_W'(irq_flag);
         default: begin
            if (addr[AW-1:2] == A_C0R[AW-1:2]) rd_val = cap_q[addr[1:0]];
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_val;
   end

   assign irq = irq_flag & irq_mask;
endmodule

// File: rtl/ect_checker.sv
module ect_checker
   import ect_pkg::*;
#(
   parameter int unsigned CAP_W = 8,
   parameter int unsigned PT_W  = 12
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic                     rd_en,
   input logic [AW-1:0]            addr,
   input logic [2*CAP_W-1:0]       frt,
   input logic [PT_W-1:0]          pt_count,
   input logic [PT_W-1:0]          pt_reload,
   input logic [N_IRQ-1:0]         irq_flag,
   input logic                     hold_mode,
   input logic [3:0]               hold_flag,
   input logic [3:0][CAP_W-1:0]    cap_q
);
   // R2
   frt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_FRT_HI) |=> frt == $past(frt) + 1'b1);

   // R7
   pt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pt_count == '0 && !(wr_en && addr == A_PT_HI))
      |=> (pt_count == $past(pt_reload)) && irq_flag[F_PT]);

   // R8
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == A_FLAG) |=> (irq_flag & $past(irq_flag)) == $past(irq_flag));

   // R6
   hold_c0r_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_mode && hold_flag[0] && !(rd_en && addr == A_C0R)) |=> $stable(cap_q[0]));

   // R6
   hold_c0f_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_mode && hold_flag[1] && !(rd_en && addr == A_C0F)) |=> $stable(cap_q[1]));
endmodule

bind edge_capture_timer ect_checker #(.CAP_W(CAP_W), .PT_W(PT_W)) u_ect_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .addr     (addr),
   .frt      (frt),
   .pt_count (pt_count),
   .pt_reload(pt_reload),
   .irq_flag (irq_flag),
   .hold_mode(hold_mode),
   .hold_flag(hold_flag),
   .cap_q    (cap_q)
);

// File: tb/tb_edge_capture_timer.sv
module tb_edge_capture_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cap_in = 2'b00;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [4:0] irq;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   edge_capture_timer dut (
      .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // preset counter to v, then change cap_in[ch] right after the load edge
   task automatic cap_edge(input int ch, input logic lvl, input logic [15:0] v);
      bus_wr(4'd0, v[7:0]);
      bus_wr(4'd1, v[15:8]);
      cap_in[ch] = lvl;
      idle(4);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 irq", irq, 0);
      bus_rd(4'd6, d); chk("R1 flags", d, 0);
      bus_rd(4'd8, d); chk("R1 c0 rise", d, 0);
      bus_rd(4'd4, d); chk("R1 ctrl", d, 0);
      bus_rd(4'd7, d); chk("R1 unmapped", d, 0);
   endtask

   task automatic t_frt();
      logic [7:0] d;
      bus_wr(4'd0, 8'h34); bus_wr(4'd1, 8'h12);
      bus_rd(4'd0, d); chk("R2 load lo", d, 8'h34);
      bus_rd(4'd1, d); chk("R2 load hi", d, 8'h12);
      bus_wr(4'd0, 8'hFE); bus_wr(4'd1, 8'hFF);
      bus_rd(4'd0, d); chk("R2 lo FE", d, 8'hFE);
      bus_rd(4'd1, d); chk("R2 hi at FFFF", d, 8'hFF);
      bus_rd(4'd0, d); chk("R2 wrap", d, 8'h00);
   endtask

   task automatic t_cap8();
      logic [7:0] d;
      cap_edge(0, 1'b1, 16'h1050); bus_rd(4'd8, d);  chk("R3 c0 rise", d, 8'h52);
      cap_edge(0, 1'b0, 16'h20A0); bus_rd(4'd9, d);  chk("R3 c0 fall", d, 8'hA2);
      cap_edge(1, 1'b1, 16'h30F0); bus_rd(4'd10, d); chk("R3 c1 rise", d, 8'hF2);
      cap_edge(1, 1'b0, 16'h4011); bus_rd(4'd11, d); chk("R3 c1 fall", d, 8'h13);
      bus_rd(4'd8, d); chk("R4 c0 rise kept", d, 8'h52);
      bus_rd(4'd9, d); chk("R4 c0 fall kept", d, 8'hA2);
      bus_rd(4'd6, d); chk("R8 all capture flags", d & 8'h0F, 8'h0F);
      bus_wr(4'd6, 8'h01);
      bus_rd(4'd6, d); chk("R8 w1c single bit", d & 8'h0F, 8'h0E);
      bus_wr(4'd6, 8'h1F);
      bus_rd(4'd6, d); chk("R8 w1c all", d & 8'h0F, 8'h00);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      bus_wr(4'd5, 8'h01);
      chk("R9 masked idle", irq, 0);
      cap_edge(0, 1'b1, 16'h0777);
      chk("R9 irq on c0 rise", irq, 5'h01);
      bus_rd(4'd8, d); chk("R3 c0 rise again", d, 8'h79);
      bus_wr(4'd5, 8'h00);
      chk("R9 mask off", irq, 0);
      bus_rd(4'd6, d); chk("R9 flag still set", d[0], 1'b1);
      bus_wr(4'd6, 8'h1F);
   endtask

   task automatic t_hold();
      logic [7:0] d;
      bus_wr(4'd4, 8'h02);
      cap_edge(0, 1'b0, 16'h0100);
      cap_edge(0, 1'b1, 16'h0210);
      cap_edge(0, 1'b0, 16'h0300);
      cap_edge(0, 1'b1, 16'h0320);
      bus_rd(4'd8, d); chk("R6 first value held", d, 8'h12);
      cap_edge(0, 1'b0, 16'h0400);
      cap_edge(0, 1'b1, 16'h0430);
      bus_rd(4'd8, d); chk("R6 rearmed after read", d, 8'h32);
      bus_wr(4'd4, 8'h00);
      bus_rd(4'd9, d);
      bus_wr(4'd6, 8'h1F);
   endtask

   task automatic t_pair();
      logic [7:0] d;
      bus_wr(4'd4, 8'h01);
      bus_wr(4'd6, 8'h1F);
      cap_edge(0, 1'b0, 16'h12FE);
      bus_rd(4'd9, d);  chk("R5 fall low byte", d, 8'h00);
      bus_rd(4'd11, d); chk("R5 fall high byte", d, 8'h13);
      cap_edge(0, 1'b1, 16'hABFF);
      bus_rd(4'd8, d);  chk("R5 rise low byte", d, 8'h01);
      bus_rd(4'd10, d); chk("R5 rise high byte", d, 8'hAC);
      cap_edge(1, 1'b1, 16'h5555);
      bus_rd(4'd10, d); chk("R5 ch1 input ignored", d, 8'hAC);
      bus_rd(4'd6, d);  chk("R5 only ch0 flags", d & 8'h0F, 8'h03);
      bus_wr(4'd4, 8'h00);
      bus_wr(4'd6, 8'h1F);
   endtask

   task automatic t_pt();
      logic [7:0] d;
      bus_wr(4'd2, 8'h05);
      bus_wr(4'd3, 8'h00);
      bus_wr(4'd6, 8'h10);
      bus_wr(4'd5, 8'h10);
      idle(3); chk("R7 not yet expired", irq[4], 1'b0);
      idle(1); chk("R7 expiry after period", irq[4], 1'b1);
      bus_wr(4'd6, 8'h10);
      chk("R8 timer flag cleared", irq[4], 1'b0);
      idle(4); chk("R7 second period pending", irq[4], 1'b0);
      idle(1); chk("R7 second expiry", irq[4], 1'b1);
      bus_rd(4'd2, d); chk("R7 period lo readback", d, 8'h05);
      bus_wr(4'd2, 8'hFF); bus_wr(4'd3, 8'h0F);
      bus_rd(4'd3, d); chk("R7 period hi readback", d, 8'h0F);
      bus_wr(4'd5, 8'h00); bus_wr(4'd6, 8'h1F);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_frt();
      t_cap8();
      t_irq();
      t_hold();
      t_pair();
      t_pt();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule